// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Register

This block is a single 64-bit control word shared by up to four processors. It tracks two kinds of per-processor interrupt: a periodic timer tick and an inter-processor interrupt (IPI). Any processor can write the word. One group of bits acknowledges timer ticks. A second group sends IPIs to any subset of processors. A third group acknowledges IPIs. On a read, the word returns the stored pending flags together with the number of the processor that is reading.

Each processor slot has its own timer interrupt line and its own IPI line, so the two sources can be serviced at different priority levels. IPIs are counted rather than latched. A processor's IPI line stays up until it has acknowledged as many IPIs as were sent to it. The number of populated processor slots is a parameter. Slots beyond that number never raise an interrupt. A write that carries none of the recognised fields is flagged as an error.

Top module: `cpu_irq_ctrl`

## Requirements
- R1: After synchronous reset, every timer and IPI line is low, every IPI count is zero, the error pulse is low, and the stored word is zero.
- R2: `rd_data` carries the timer flags in bits 7:4 (bit 4+i for slot i) and the IPI flags in bits 11:8 (bit 8+i). The reader's number `acc_cpu` appears in bits 1:0. All other bits read zero. A read returns the state held before any write in the same cycle.
- R3: A `tick` sets the timer flag and raises `timer_irq[i]` on the next cycle for every populated slot. A slot whose flag is already set stays set.
- R4: Writing a one to bit 4+i clears slot i's timer flag and drops `timer_irq[i]` on the next cycle. If a tick arrives in the same cycle, the tick wins and the flag stays set.
- R5: Writing a one to bit 12+i sets slot i's IPI flag (bit 8+i) and adds one to its count. `ipi_irq[i]` is high on the next cycle.
- R6: Writing a one to bit 8+i clears bit 8+i and subtracts one from a non-zero count. A zero count stays zero. `ipi_irq[i]` is high exactly while the count is non-zero.
- R7: An IPI count is 4 bits wide and holds at 15 when a further IPI is sent.
- R8: Within one write, the fields are applied in this order: timer acknowledge, then IPI send, then IPI acknowledge. Send and acknowledge for the same slot leave a count of 0 at 0 and take a count of 15 to 14, and the slot's IPI flag ends cleared.
- R9: A write whose only set bit among the recognised ones is bit 28 is accepted. It changes nothing and raises no error.
- R10: A write with all of bits 15:4 and bit 28 at zero raises `wr_err` for one cycle, on the cycle after the write, and leaves the state unchanged.
- R11: Fields that target slots at or beyond `NUM_CPUS` are ignored: those slots never raise either line and their count stays zero. Such a write still counts as recognised, so it raises no error.
- R12: `ipi_count` presents slot i's count in bits 4i+3:4i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick pulse from the external timer |
| acc_cpu | input | 2 | Number of the processor making the access |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read value of the control word (combinational) |
| timer_irq | output | 4 | Timer interrupt line, one per slot |
| ipi_irq | output | 4 | Inter-processor interrupt line, one per slot |
| ipi_count | output | 16 | Pending IPI counts, 4 bits per slot |
| wr_err | output | 1 | One-cycle pulse after an unsupported write |

## Verification
Two pairs of functions can land in the same cycle. A timer tick can coincide with a write that acknowledges that slot's tick. An IPI send can coincide with an acknowledge for the same slot. The bench provokes both by driving tick and a write together, and by writing send and acknowledge bits in one word, both at count 0 and at the saturated count of 15. A behavioural reference model applies the fixed order (acknowledge timer, then tick, then send, then acknowledge IPI) and is compared against every output on every clock.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

    localparam int SLOTS     = 4;
    localparam int WORD_W    = 64;
    localparam int ID_W      = 2;
    localparam int TACK_LSB  = 4;
    localparam int IACK_LSB  = 8;
    localparam int ISEND_LSB = 12;
    localparam int NXM_BIT   = 28;

    typedef logic [SLOTS-1:0]  slot_vec_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        slot_vec_t tmr_ack;
        slot_vec_t ipi_send;
        slot_vec_t ipi_ack;
        logic      nxm_ack;
        logic      known;
    } wr_fields_t;

    function automatic word_t pack_read(input slot_vec_t tmr,
                                        input slot_vec_t ipi,
                                        input logic [ID_W-1:0] id);
        word_t w;
        w = '0;
        w[TACK_LSB +: SLOTS] = tmr;
        w[IACK_LSB +: SLOTS] = ipi;
        w[ID_W-1:0]          = id;
        return w;
    endfunction

    function automatic slot_vec_t active_mask(input int n);
        slot_vec_t m;
        for (int i = 0; i < SLOTS; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/cpu_irq_wdec.sv
module cpu_irq_wdec
    import cpu_irq_pkg::*;
#(
    parameter int NUM_CPUS = SLOTS
) (
    input  logic       wr_en,
    input  word_t      wr_data,
    output wr_fields_t fields,
    output logic       bad_wr
);
    localparam slot_vec_t LIVE = active_mask(NUM_CPUS);

    slot_vec_t raw_tack, raw_isend, raw_iack;

    always_comb begin
        raw_tack  = wr_data[TACK_LSB  +: SLOTS];
        raw_isend = wr_data[ISEND_LSB +: SLOTS];
        raw_iack  = wr_data[IACK_LSB  +: SLOTS];

        fields.tmr_ack  = wr_en ? (raw_tack  & LIVE) : '0;
        fields.ipi_send = wr_en ? (raw_isend & LIVE) : '0;
        fields.ipi_ack  = wr_en ? (raw_iack  & LIVE) : '0;
        fields.nxm_ack  = wr_en & wr_data[NXM_BIT];
        fields.known    = (|raw_tack) | (|raw_isend) | (|raw_iack)
                          | wr_data[NXM_BIT];
        bad_wr          = wr_en & ~fields.known;
    end
endmodule

// File: rtl/cpu_irq_tmr.sv
module cpu_irq_tmr
    import cpu_irq_pkg::*;
#(
    parameter int NUM_CPUS = SLOTS
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  slot_vec_t ack,
    output slot_vec_t pend
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_CPUS) begin : g_live
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_q <= 1'b0;
                end else begin
                    flag_q <= (flag_q & ~ack[i]) | tick;
                end
            end
            assign pend[i] = flag_q;
        end else begin : g_empty
            assign pend[i] = 1'b0;
        end
    end
endmodule

// File: rtl/cpu_irq_ipi.sv
module cpu_irq_ipi #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             send,
    input  logic             ack,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q, after_send, after_ack;
    logic             flag_q;

    always_comb begin
        after_send = cnt_q;
        if (send && cnt_q != CNT_MAX) begin
            after_send = cnt_q + 1'b1;
        end
        after_ack = after_send;
        if (ack && after_send != '0) begin
            after_ack = after_send - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= after_ack;
            flag_q <= (flag_q | send) & ~ack;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;
    assign irq  = (cnt_q != '0);
endmodule

// File: rtl/cpu_irq_ctrl.sv
module cpu_irq_ctrl
    import cpu_irq_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int CNT_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [1:0]             acc_cpu,
    input  logic                   wr_en,
    input  logic [63:0]            wr_data,
    output logic [63:0]            rd_data,
    output logic [3:0]             timer_irq,
    output logic [3:0]             ipi_irq,
    output logic [4*CNT_W-1:0]     ipi_count,
    output logic                   wr_err
);
    wr_fields_t fields;
    logic       bad_wr;
    slot_vec_t  tmr_pend;
    slot_vec_t  ipi_flag;
    slot_vec_t  ipi_line;
    logic       err_q;

    cpu_irq_wdec #(.NUM_CPUS(NUM_CPUS)) u_wdec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fields  (fields),
        .bad_wr  (bad_wr)
    );

    cpu_irq_tmr #(.NUM_CPUS(NUM_CPUS)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .ack  (fields.tmr_ack),
        .pend (tmr_pend)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_ipi
        cpu_irq_ipi #(.CNT_W(CNT_W)) u_ipi (
            .clk  (clk),
            .rst  (rst),
            .send (fields.ipi_send[i]),
            .ack  (fields.ipi_ack[i]),
            .cnt  (ipi_count[i*CNT_W +: CNT_W]),
            .flag (ipi_flag[i]),
            .irq  (ipi_line[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= bad_wr;
        end
    end

    assign rd_data   = pack_read(tmr_pend, ipi_flag, acc_cpu);
    assign timer_irq = tmr_pend;
    assign ipi_irq   = ipi_line;
    assign wr_err    = err_q;
endmodule

// File: rtl/cpu_irq_ctrl_chk.sv
module cpu_irq_ctrl_chk
    import cpu_irq_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int CNT_W    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic [1:0]         acc_cpu,
    input logic               wr_en,
    input logic [63:0]        wr_data,
    input logic [63:0]        rd_data,
    input logic [3:0]         timer_irq,
    input logic [3:0]         ipi_irq,
    input logic [4*CNT_W-1:0] ipi_count,
    input logic               wr_err
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> ($past(wr_en) && $past(wr_data[15:4]) == '0 && !$past(wr_data[NXM_BIT])));

    // R2
    rd_id_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[1:0] == acc_cpu);

    for (genvar i = 0; i < SLOTS; i++) begin : g_chk
        if (i < NUM_CPUS) begin : g_live
            // R3
            tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> timer_irq[i]);
            // R4
            tack_clears_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_data[TACK_LSB+i] && !tick) |=> !timer_irq[i]);
            // R5
            send_raises_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_data[ISEND_LSB+i] && !wr_data[IACK_LSB+i]) |=> ipi_irq[i]);
            // R6
            ipi_drop_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(ipi_irq[i]) |-> $past(wr_en && wr_data[IACK_LSB+i]));
            // R7
            ipi_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (ipi_count[i*CNT_W +: CNT_W] == TOP && wr_en && !wr_data[IACK_LSB+i])
                |=> ipi_count[i*CNT_W +: CNT_W] == TOP);
        end else begin : g_empty
            // R11
            empty_slot_chk: assert property (@(posedge clk) disable iff (rst)
                !timer_irq[i] && !ipi_irq[i] && ipi_count[i*CNT_W +: CNT_W] == '0);
        end
    end
endmodule

bind cpu_irq_ctrl cpu_irq_ctrl_chk #(.NUM_CPUS(NUM_CPUS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_cpu_irq_ctrl.sv
module test_cpu_irq_ctrl;
    localparam int NCPU = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  acc_cpu = 2'd0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic [3:0]  timer_irq;
    logic [3:0]  ipi_irq;
    logic [15:0] ipi_count;
    logic        wr_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string cur = "R1";

    int m_cnt [4];
    bit m_tmr [4];
    bit m_ipi [4];
    bit m_err;

    always #4 clk = ~clk;

    cpu_irq_ctrl #(.NUM_CPUS(NCPU), .CNT_W(4)) i_cpu_irq_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .acc_cpu(acc_cpu),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .timer_irq(timer_irq), .ipi_irq(ipi_irq),
        .ipi_count(ipi_count), .wr_err(wr_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] m_read(input logic [1:0] id);
        logic [63:0] w = 64'(id);
        for (int i = 0; i < 4; i++) begin
            if (m_tmr[i]) w[4+i] = 1'b1;
            if (m_ipi[i]) w[8+i] = 1'b1;
        end
        return w;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 0; m_tmr[i] = 0; m_ipi[i] = 0;
        end
        m_err = 0;
    endtask

    task automatic m_step(input logic tk, input logic we, input logic [63:0] d);
        m_err = we && d[15:4] == 12'h0 && !d[28];
        for (int i = 0; i < NCPU; i++) begin
            if (we && d[4+i]) m_tmr[i] = 0;
            if (tk) m_tmr[i] = 1;
            if (we && d[12+i]) begin
                m_ipi[i] = 1;
                if (m_cnt[i] < 15) m_cnt[i]++;
            end
            if (we && d[8+i]) begin
                m_ipi[i] = 0;
                if (m_cnt[i] > 0) m_cnt[i]--;
            end
        end
    endtask

    task automatic cmp_state();
        logic [3:0]  et, ei;
        logic [15:0] ec;
        for (int i = 0; i < 4; i++) begin
            et[i] = m_tmr[i];
            ei[i] = (m_cnt[i] != 0);
            ec[i*4 +: 4] = 4'(m_cnt[i]);
        end
        chk(cur, "timer_irq", 64'(timer_irq), 64'(et));
        chk(cur, "ipi_irq", 64'(ipi_irq), 64'(ei));
        chk(cur, "ipi_count", 64'(ipi_count), 64'(ec));
        chk(cur, "wr_err", 64'(wr_err), 64'(m_err));
    endtask

    task automatic step(input logic tk, input logic [1:0] id,
                        input logic we, input logic [63:0] d);
        tick = tk; acc_cpu = id; wr_en = we; wr_data = d;
        #2;
        chk(cur, "rd_data", rd_data, m_read(id));
        @(posedge clk);
        m_step(tk, we, d);
        @(negedge clk);
        cmp_state();
        tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wr(input logic [1:0] id, input logic [63:0] d);
        step(1'b0, id, 1'b1, d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        cur = "R1";
        cmp_state();
        step(1'b0, 2'd0, 1'b0, '0);
        // R2: read id in low bits
        cur = "R2";
        for (int k = 0; k < 4; k++) step(1'b0, 2'(k), 1'b0, '0);
        // R3: tick, repeated tick
        cur = "R3";
        step(1'b1, 2'd1, 1'b0, '0);
        step(1'b1, 2'd2, 1'b0, '0);
        chk("R3", "rd_data flags", rd_data & 64'hF0, 64'h70);
        // R4: ack slot1, then ack slot0 with tick in same cycle
        cur = "R4";
        wr(2'd0, 64'h20);
        step(1'b1, 2'd0, 1'b1, 64'h10);
        chk("R4", "timer_irq after ack+tick", 64'(timer_irq), 64'h7);
        wr(2'd0, 64'h70);
        // R5: send to slots 0 and 2, then slot 0 again
        cur = "R5";
        wr(2'd1, 64'h5000);
        wr(2'd2, 64'h1000);
        // R6: ack slot 0 twice, then ack at zero
        cur = "R6";
        wr(2'd0, 64'h100);
        chk("R6", "ipi_irq slot0 held", 64'(ipi_irq[0]), 64'h1);
        step(1'b0, 2'd0, 1'b0, '0);
        wr(2'd0, 64'h100);
        chk("R6", "ipi_irq slot0 dropped", 64'(ipi_irq[0]), 64'h0);
        wr(2'd0, 64'h100);
        // R7: saturate slot 1
        cur = "R7";
        for (int k = 0; k < 17; k++) wr(2'd3, 64'h2000);
        // R12: count field position
        cur = "R12";
        chk("R12", "ipi_count slot1", 64'(ipi_count[7:4]), 64'hF);
        // R8: ordering, saturated send+ack and timer ack in one word
        cur = "R8";
        step(1'b1, 2'd0, 1'b0, '0);
        wr(2'd1, 64'h2220);
        chk("R8", "slot1 count", 64'(ipi_count[7:4]), 64'hE);
        wr(2'd1, 64'h4400);
        chk("R8", "slot2 count", 64'(ipi_count[11:8]), 64'h1);
        for (int k = 0; k < 14; k++) wr(2'd1, 64'h200);
        // R9: bit 28 alone
        cur = "R9";
        wr(2'd2, 64'h1000_0000);
        // R10: unsupported writes
        cur = "R10";
        wr(2'd0, 64'hFFFF_FFFF_EFFF_000F);
        chk("R10", "wr_err", 64'(wr_err), 64'h1);
        step(1'b0, 2'd0, 1'b0, '0);
        wr(2'd0, 64'h0);
        // R11: slot 3 is not populated
        cur = "R11";
        wr(2'd3, 64'h8000);
        step(1'b1, 2'd3, 1'b0, '0);
        wr(2'd3, 64'h8880);
        chk("R11", "slot3 lines", 64'({timer_irq[3], ipi_irq[3]}), 64'h0);
        // R1: reset in the middle of activity
        cur = "R1";
        wr(2'd0, 64'h7000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_reset();
        cmp_state();
        chk("R1", "rd_data", rd_data, 64'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule